// File: doc/BRIEF.md
# Serial Management Port Target

This block is the device-side end of a two-wire serial management link. The station supplies a management clock and a shared, open-drain data line. This block sees the line as three signals: a sampled input, a driven value and a drive enable. Up to 32 devices can share the line. The block answers only frames whose 5-bit device field equals the `own_addr` strap. It turns each accepted frame into one access on a simple register port, so the register bank that holds the contents can sit next to it.

Frames are accepted only after synchronization. After reset the block must count 32 consecutive clock cycles with the line high. After that it accepts frames back to back with no preamble. A malformed start, an unknown opcode or a bad write turnaround drops it back to the unsynchronized state.

The frame state machine has seven states:
- `ST_IDLE` waits for a 0 while synchronized and then goes to `ST_START`.
- `ST_START` needs a 1 and then goes to `ST_OPCODE`; a 0 here is an error and returns to `ST_IDLE`.
- `ST_OPCODE` takes two bits. A valid code leads to `ST_DEVADR`; any other code is an error and returns to `ST_IDLE`.
- `ST_DEVADR` and then `ST_REGADR` each take five bits.
- `ST_TURN` takes two bits. A bad write pattern is an error and returns to `ST_IDLE`.
- `ST_DATA` takes sixteen bits and then returns to `ST_IDLE`.

A separate preamble tracker holds the synchronized flag.

Top module: `mgmt_serial_target`

## Requirements
- R1: After reset, `line_oe`, `reg_re` and `reg_we` are 0. No frame is recognised until 32 consecutive rising clock edges have sampled the line high; after only 31 ones, a following valid frame gets no response.
- R2: Once synchronized, frames sent back to back with no preamble between them are all accepted.
- R3: A frame starts with the first 0 seen while idle, and that 0 must be followed by a 1. A 0 in that second position is an invalid start. It clears synchronization, so the next frame is ignored until 32 more ones arrive. While synchronized, ones on an idle line are ignored.
- R4: The opcode is the two bits after the start, first-sent bit listed first: `10` is a read and `01` is a write. `00` and `11` are invalid and clear synchronization.
- R5: After the opcode come a 5-bit device field and then a 5-bit register field, each most significant bit first. On an addressed frame, `reg_addr` takes the register field.
- R6: On an addressed read, `reg_re` is high for exactly one cycle, starting at the rising edge that samples the last register-field bit. `reg_rdata` is captured at the next rising edge.
- R7: On an addressed read, the line is left undriven for the first turnaround bit and driven 0 for the second. Then the 16 captured data bits are driven, most significant bit first. Each driven value changes on a falling edge, and the drive is released at the falling edge after the last data bit.
- R8: On a write (addressed or not), the turnaround must arrive as 1 then 0. Any other pattern discards the write and clears synchronization.
- R9: On an addressed write, `reg_we` is high for exactly one cycle after the rising edge that samples the 16th data bit. In that cycle `reg_wdata` holds the data field, most significant bit first.
- R10: When the device field differs from `own_addr`, the block never drives the line and raises neither strobe. It stays synchronized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mgmt_clk | input | 1 | Management clock from the station |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 5 | Device address this target answers to |
| line_in | input | 1 | Sampled value of the shared data line |
| line_out | output | 1 | Value driven onto the data line |
| line_oe | output | 1 | Drive enable for the data line |
| reg_addr | output | 5 | Register address for the access |
| reg_wdata | output | 16 | Write data for the register bank |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Read data returned for `reg_addr` |
| reg_re | output | 1 | One-cycle read strobe |

## Verification
The bench changes the line at each falling edge and samples every output 5 ns later, so each frame bit has one sample. Counting frame bits from 0 at the first start bit:
- `reg_re` is due in sample 14.
- The turnaround zero is driven in sample 15.
- Read data bit 15−j is driven in sample 16+j.
- `reg_we` and the released line are due in sample 32.

Each check compares whole per-frame vectors of these samples against masks computed from those indices. A shift by even one cycle therefore counts as a failure.

// File: rtl/mgmt_pkg.sv
`timescale 1ns/1ps
package mgmt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_OPCODE,
        ST_DEVADR,
        ST_REGADR,
        ST_TURN,
        ST_DATA
    } frame_state_e;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;

endpackage

// File: rtl/mgmt_preamble_sync.sv
`timescale 1ns/1ps
module mgmt_preamble_sync #(
    parameter int PRE_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic clr_i,
    output logic synced_o
);
    localparam int CW = $clog2(PRE_LEN);
    localparam logic [CW-1:0] ONES_LAST = CW'(PRE_LEN - 1);

    logic [CW-1:0] ones_q;
    logic          synced_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ones_q   <= '0;
            synced_q <= 1'b0;
        end else if (clr_i) begin
            ones_q   <= '0;
            synced_q <= 1'b0;
        end else if (!synced_q) begin
            if (!bit_i) begin
                ones_q <= '0;
            end else if (ones_q == ONES_LAST) begin
                ones_q   <= '0;
                synced_q <= 1'b1;
            end else begin
                ones_q <= ones_q + 1'b1;
            end
        end
    end

    assign synced_o = synced_q;

    // R3, R4, R8: a protocol error leaves the port unsynchronized
    a_r3_error_drops_sync: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !synced_q);

    // R1: synchronization is only gained on a sampled one
    a_r1_sync_on_one: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(synced_q) |-> $past(bit_i));

endmodule

// File: rtl/mgmt_frame_fsm.sv
`timescale 1ns/1ps
module mgmt_frame_fsm
    import mgmt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_i,
    input  logic              synced_i,
    input  logic [ADDR_W-1:0] own_addr_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              err_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              reg_we_o,
    output logic              reg_re_o,
    output logic              drv_en_o,
    output logic              drv_bit_o
);
    localparam int CNT_W = $clog2((DATA_W > ADDR_W) ? DATA_W : ADDR_W);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

    frame_state_e      state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic              op_first_q;
    logic              is_rd_q;
    logic              hit_q;
    logic [ADDR_W-1:0] dev_q;
    logic [ADDR_W-2:0] ra_q;
    logic [DATA_W-1:0] shift_q;
    logic              re_q, we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              err;

    logic [1:0] op_full;
    logic       addr_last, data_last, dev_match, ta_expect;

    assign op_full   = {op_first_q, bit_i};
    assign addr_last = (cnt_q == ADDR_LAST);
    assign data_last = (cnt_q == DATA_LAST);
    assign dev_match = (dev_q == own_addr_i);
    assign ta_expect = (cnt_q == '0);

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        err     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (synced_i && !bit_i) begin
                    state_d = ST_START;
                end
            end
            ST_START: begin
                if (bit_i) begin
                    state_d = ST_OPCODE;
                    cnt_d   = '0;
                end else begin
                    err     = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_OPCODE: begin
                if (cnt_q == '0) begin
                    cnt_d = cnt_q + 1'b1;
                end else if (op_full == OP_READ || op_full == OP_WRITE) begin
                    state_d = ST_DEVADR;
                    cnt_d   = '0;
                end else begin
                    err     = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_DEVADR: begin
                if (addr_last) begin
                    state_d = ST_REGADR;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_REGADR: begin
                if (addr_last) begin
                    state_d = ST_TURN;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_TURN: begin
                if (!is_rd_q && (bit_i != ta_expect)) begin
                    err     = 1'b1;
                    state_d = ST_IDLE;
                end else if (cnt_q == '0) begin
                    cnt_d = cnt_q + 1'b1;
                end else begin
                    state_d = ST_DATA;
                    cnt_d   = '0;
                end
            end
            ST_DATA: begin
                if (data_last) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register and field capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            op_first_q <= 1'b0;
            is_rd_q    <= 1'b0;
            hit_q      <= 1'b0;
            dev_q      <= '0;
            ra_q       <= '0;
            shift_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (state_q == ST_OPCODE) begin
                op_first_q <= bit_i;
                if (cnt_q != '0) begin
                    is_rd_q <= (op_full == OP_READ);
                end
            end
            if (state_q == ST_DEVADR) begin
                dev_q <= {dev_q[ADDR_W-2:0], bit_i};
            end
            if (state_q == ST_REGADR) begin
                ra_q <= {ra_q[ADDR_W-3:0], bit_i};
                if (addr_last) begin
                    hit_q <= dev_match;
                end
            end
            if (state_q == ST_TURN && cnt_q == '0 && re_q) begin
                shift_q <= rd_data_i;
            end else if (state_q == ST_DATA) begin
                shift_q <= {shift_q[DATA_W-2:0], bit_i};
            end
        end
    end

    // registered register-port outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            re_q    <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            re_q <= (state_q == ST_REGADR) && addr_last && is_rd_q && dev_match;
            we_q <= (state_q == ST_DATA) && data_last && !is_rd_q && hit_q;
            if (state_q == ST_REGADR && addr_last && dev_match) begin
                addr_q <= {ra_q, bit_i};
            end
            if (state_q == ST_DATA && data_last && !is_rd_q && hit_q) begin
                wdata_q <= {shift_q[DATA_W-2:0], bit_i};
            end
        end
    end

    assign err_o       = err;
    assign reg_re_o    = re_q;
    assign reg_we_o    = we_q;
    assign reg_addr_o  = addr_q;
    assign reg_wdata_o = wdata_q;
    assign drv_en_o    = hit_q && is_rd_q &&
                         ((state_q == ST_TURN && cnt_q != '0) || state_q == ST_DATA);
    assign drv_bit_o   = (state_q == ST_DATA) ? shift_q[DATA_W-1] : 1'b0;

    // R6: read strobe lasts a single cycle
    a_r6_re_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re_o |=> !reg_re_o);

    // R9: write strobe lasts a single cycle
    a_r9_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);

    // R9: write strobe appears only once the frame has ended
    a_r9_we_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> (state_q == ST_IDLE));

    // R1: nothing is driven while unsynchronized
    a_r1_drive_needs_sync: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en_o |-> synced_i);

    // R6, R7: driving starts only after the register fetch
    a_r7_fetch_before_drive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en_o) |-> $past(reg_re_o));

    // R8: any protocol error ends the frame
    a_r8_error_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> (state_q == ST_IDLE));

endmodule

// File: rtl/mgmt_drive_stage.sv
`timescale 1ns/1ps
module mgmt_drive_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_en_i,
    input  logic drv_bit_i,
    output logic line_out_o,
    output logic line_oe_o
);
    logic oe_q, out_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_q  <= 1'b0;
            out_q <= 1'b0;
        end else begin
            oe_q  <= drv_en_i;
            out_q <= drv_en_i & drv_bit_i;
        end
    end

    assign line_out_o = out_q;
    assign line_oe_o  = oe_q;

    // R7: the first driven bit of a reply is the turnaround zero
    a_r7_first_bit_zero: assert property (@(negedge clk) disable iff (!rst_n)
        $rose(oe_q) |-> !out_q);

endmodule

// File: rtl/mgmt_serial_target.sv
`timescale 1ns/1ps
module mgmt_serial_target #(
    parameter int ADDR_W  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_LEN = 32
) (
    input  logic              mgmt_clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              line_in,
    output logic              line_out,
    output logic              line_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_re
);
    logic synced, proto_err, drv_en, drv_bit;

    mgmt_preamble_sync #(.PRE_LEN(PRE_LEN)) u_sync (
        .clk      (mgmt_clk),
        .rst_n    (rst_n),
        .bit_i    (line_in),
        .clr_i    (proto_err),
        .synced_o (synced)
    );

    mgmt_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk         (mgmt_clk),
        .rst_n       (rst_n),
        .bit_i       (line_in),
        .synced_i    (synced),
        .own_addr_i  (own_addr),
        .rd_data_i   (reg_rdata),
        .err_o       (proto_err),
        .reg_addr_o  (reg_addr),
        .reg_wdata_o (reg_wdata),
        .reg_we_o    (reg_we),
        .reg_re_o    (reg_re),
        .drv_en_o    (drv_en),
        .drv_bit_o   (drv_bit)
    );

    mgmt_drive_stage u_drive (
        .clk        (mgmt_clk),
        .rst_n      (rst_n),
        .drv_en_i   (drv_en),
        .drv_bit_i  (drv_bit),
        .line_out_o (line_out),
        .line_oe_o  (line_oe)
    );

endmodule

// File: tb/mgmt_serial_target_tb.sv
`timescale 1ns/1ps
module mgmt_serial_target_tb;
    logic        mgmt_clk = 1'b0;
    logic        rst_n;
    logic [4:0]  own_addr = 5'd19;
    logic        tb_en, tb_bit;
    logic        line_in, line_out, line_oe;
    logic [4:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        reg_we, reg_re;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [33:0] s_oe, s_o, s_re, s_we;
    logic [4:0]  cap_addr, cap_waddr;
    logic [15:0] cap_wd;

    always #10 mgmt_clk = ~mgmt_clk;

    assign line_in = line_oe ? line_out : (tb_en ? tb_bit : 1'b1);

    function automatic logic [15:0] rd_pattern(input logic [4:0] a);
        return 16'h5A3C ^ (16'(a) * 16'd1291);
    endfunction

    function automatic logic [15:0] wr_pattern(input logic [4:0] a);
        return 16'h2C81 + (16'(a) * 16'h0B13);
    endfunction

    assign reg_rdata = rd_pattern(reg_addr);

    mgmt_serial_target u_dut (
        .mgmt_clk (mgmt_clk),
        .rst_n    (rst_n),
        .own_addr (own_addr),
        .line_in  (line_in),
        .line_out (line_out),
        .line_oe  (line_oe),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .reg_rdata(reg_rdata),
        .reg_re   (reg_re)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_ones(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge mgmt_clk);
            tb_en  = 1'b1;
            tb_bit = 1'b1;
        end
    endtask

    task automatic run_frame(input logic [1:0] st, input logic [1:0] op,
                             input logic [4:0] dev, input logic [4:0] ra,
                             input logic [1:0] ta, input logic [15:0] wd,
                             input bit release_tail);
        logic [31:0] bits;
        bits = {st, op, dev, ra, ta, wd};
        s_oe = '0; s_o = '0; s_re = '0; s_we = '0;
        for (int i = 0; i < 34; i++) begin
            @(negedge mgmt_clk);
            if (i < 32) begin
                tb_en  = !(release_tail && i >= 14);
                tb_bit = bits[31-i];
            end else begin
                tb_en  = 1'b1;
                tb_bit = 1'b1;
            end
            #5;
            s_oe[i] = line_oe;
            s_o[i]  = line_out;
            s_re[i] = reg_re;
            s_we[i] = reg_we;
            if (reg_re) cap_addr = reg_addr;
            if (reg_we) begin
                cap_wd    = reg_wdata;
                cap_waddr = reg_addr;
            end
        end
    endtask

    task automatic read_hit(input logic [4:0] ra, input string req);
        logic [33:0] exp_oe;
        logic [15:0] word;
        run_frame(2'b01, 2'b10, own_addr, ra, 2'b11, 16'hFFFF, 1'b1);
        exp_oe = '0;
        for (int i = 15; i < 32; i++) exp_oe[i] = 1'b1;
        for (int j = 0; j < 16; j++) word[15-j] = s_o[16+j];
        chk(s_re == (34'd1 << 14), req, "R6 read strobe timing", s_re, 34'd1 << 14);
        chk(cap_addr == ra, req, "R5 reg_addr on read", cap_addr, ra);
        chk(s_oe == exp_oe, req, "R7 drive enable window", s_oe, exp_oe);
        chk(s_o[15] == 1'b0, req, "R7 turnaround zero", s_o[15], 0);
        chk(word == rd_pattern(ra), req, "R7 read data MSB first", word, rd_pattern(ra));
        chk(s_we == '0, req, "R6 no write strobe on read", s_we, 0);
    endtask

    task automatic write_hit(input logic [4:0] ra, input logic [15:0] wd, input string req);
        run_frame(2'b01, 2'b01, own_addr, ra, 2'b10, wd, 1'b0);
        chk(s_we == (34'd1 << 32), req, "R9 write strobe timing", s_we, 34'd1 << 32);
        chk(cap_wd == wd, req, "R9 write data", cap_wd, wd);
        chk(cap_waddr == ra, req, "R5 reg_addr on write", cap_waddr, ra);
        chk(s_oe == '0 && s_re == '0, req, "R9 no drive or read on write", {s_oe, s_re}, 0);
    endtask

    task automatic expect_silent(input string req, input string what);
        chk(s_oe == '0 && s_re == '0 && s_we == '0, req, what, {s_oe, s_re, s_we}, 0);
    endtask

    // after an error: next frame ignored, then 32 ones restore service
    task automatic confirm_resync(input string req);
        run_frame(2'b01, 2'b10, own_addr, 5'd3, 2'b11, 16'hFFFF, 1'b1);
        expect_silent(req, "frame ignored after error");
        send_ones(32);
        read_hit(5'd3, req);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n  = 1'b0;
        tb_en  = 1'b1;
        tb_bit = 1'b1;
        repeat (3) @(posedge mgmt_clk);
        #5;
        chk(line_oe == 1'b0 && reg_re == 1'b0 && reg_we == 1'b0, "R1", "reset state",
            {line_oe, reg_re, reg_we}, 0);
        @(negedge mgmt_clk);
        rst_n  = 1'b1;
        tb_bit = 1'b0;

        // R1: 31 ones are not enough
        send_ones(31);
        run_frame(2'b01, 2'b10, own_addr, 5'd7, 2'b11, 16'hFFFF, 1'b1);
        expect_silent("R1", "frame after 31 ones ignored");
        send_ones(32);
        read_hit(5'd7, "R1");

        // R2/R5/R6/R7: back-to-back reads over every register
        for (int r = 0; r < 32; r++) read_hit(5'(r), "R2");

        // R9: back-to-back writes over every register
        for (int r = 0; r < 32; r++) write_hit(5'(r), wr_pattern(5'(r)), "R9");

        // R10: every other device address gets no response
        for (int d = 0; d < 32; d++) begin
            if (5'(d) != own_addr) begin
                run_frame(2'b01, 2'b10, 5'(d), 5'(d), 2'b11, 16'hFFFF, 1'b1);
                expect_silent("R10", "foreign read");
                run_frame(2'b01, 2'b01, 5'(d), 5'(d), 2'b10, wr_pattern(5'(d)), 1'b0);
                expect_silent("R10", "foreign write");
            end
        end
        read_hit(5'd12, "R10");

        // R3: idle ones while synced, then a good frame
        send_ones(5);
        read_hit(5'd30, "R3");

        // R3: invalid start 00
        run_frame(2'b00, 2'b10, own_addr, 5'd4, 2'b10, 16'h1234, 1'b0);
        expect_silent("R3", "invalid start");
        confirm_resync("R3");

        // R4: invalid opcodes 11 and 00
        run_frame(2'b01, 2'b11, own_addr, 5'd4, 2'b10, 16'h0F0F, 1'b0);
        expect_silent("R4", "opcode 11");
        confirm_resync("R4");
        run_frame(2'b01, 2'b00, own_addr, 5'd4, 2'b10, 16'h0F0F, 1'b0);
        expect_silent("R4", "opcode 00");
        confirm_resync("R4");

        // R8: bad write turnarounds
        run_frame(2'b01, 2'b01, own_addr, 5'd9, 2'b00, 16'h0F0F, 1'b0);
        expect_silent("R8", "turnaround 00 discards write");
        confirm_resync("R8");
        run_frame(2'b01, 2'b01, own_addr, 5'd9, 2'b11, 16'h0F0F, 1'b0);
        expect_silent("R8", "turnaround 11 discards write");
        confirm_resync("R8");
        run_frame(2'b01, 2'b01, 5'd2, 5'd9, 2'b01, 16'h0F0F, 1'b0);
        expect_silent("R8", "foreign write with bad turnaround");
        confirm_resync("R8");

        // R2: write then read with no gap
        write_hit(5'd21, 16'h8001, "R2");
        read_hit(5'd21, "R2");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule